// File: doc/BRIEF.md
# Dual-Enable Latched Bus Transceiver

This block moves data in both directions between an A-side bus and a B-side bus. The buses are split into independent halves, two halves of eight bits by default. Each half stores data separately for each direction, so the A-to-B value and the B-to-A value are held independently. Each direction has three active-low controls: a direction enable, a latch enable and an output enable. A stored value is loaded when both the direction enable and the latch enable are low. The opposite side's pads are driven only when both the direction enable and the output enable are low.

Tri-state pads appear as three separate signals per port: an input, an output value and an output-enable flag. The pad resolution stays outside the block. The latch behaviour is reproduced in one clock domain. In each cycle where both gating controls are sampled low, the storage loads its input. The first cycle where either control is sampled high captures the value, and the value is then held. A per-half flag warns when both directions would drive at once.

Top module: `dual_latch_xcvr`

## Requirements
- R1: While `rst` is high, all output-enable flags and contention flags are 0. A clock edge with `rst` high clears every stored value in both directions of every half to 0.
- R2: At a clock edge where `ab_en_n` and `ab_le_n` of a half are both sampled 0, that half's A-to-B storage takes the half's `a_in` slice. The new value appears on `b_out` after that edge.
- R3: At a clock edge where `ab_en_n` of a half is sampled 1, that half's A-to-B storage keeps its value, whatever `a_in` and the latch enable do.
- R4: At a clock edge where `ab_le_n` of a half is sampled 1, that half's A-to-B storage keeps its value, whatever `a_in` and the direction enable do.
- R5: `b_oe[h]` is 1 in the same cycle exactly when `ab_en_n[h]` and `ab_oe_n[h]` are both 0 and `rst` is 0.
- R6: `b_out` always presents the A-to-B stored value, whether or not `b_oe` is set. `a_out` likewise presents the B-to-A stored value.
- R7: The B-to-A direction obeys R2 to R5 with `ba_en_n`, `ba_le_n` and `ba_oe_n`: it loads from `b_in` and drives `a_out` and `a_oe`.
- R8: Loading one direction never changes the value stored for the other direction of the same half.
- R9: Controls of one half never change the stored values or the enables of another half. Half h occupies data bits [h*HALF_W +: HALF_W] and control bit h.
- R10: `contention[h]` is 1 exactly when `a_oe[h]` and `b_oe[h]` are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ab_en_n | input | HALVES | A-to-B direction enable per half, active low |
| ab_le_n | input | HALVES | A-to-B latch enable per half, active low |
| ab_oe_n | input | HALVES | A-to-B output enable per half, active low |
| ba_en_n | input | HALVES | B-to-A direction enable per half, active low |
| ba_le_n | input | HALVES | B-to-A latch enable per half, active low |
| ba_oe_n | input | HALVES | B-to-A output enable per half, active low |
| a_in | input | HALVES*HALF_W | Value sensed on the A-side pads |
| a_out | output | HALVES*HALF_W | Value offered to the A-side pads (B-to-A storage) |
| a_oe | output | HALVES | A-side pad drive enable per half |
| b_in | input | HALVES*HALF_W | Value sensed on the B-side pads |
| b_out | output | HALVES*HALF_W | Value offered to the B-side pads (A-to-B storage) |
| b_oe | output | HALVES | B-side pad drive enable per half |
| contention | output | HALVES | Both sides of a half driven at once |

## Verification
In a single cycle, a half can load both of its directions and can also enable both of its drivers. Those two events then fall on the same edge and in the same cycle. The sweep walks every combination of the twelve control bits for both halves while the data on both sides changes each cycle. This provokes simultaneous loads, one-sided loads, captures caused by either gating signal, and double-drive conditions. The cross-direction and cross-half cases are judged against a bench model of four independent storage registers, together with the enable and contention equations.

// File: rtl/dual_latch_xcvr.sv
module dual_latch_xcvr #(
  parameter int HALF_W = 8,
  parameter int HALVES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [HALVES-1:0]        ab_en_n,
  input  logic [HALVES-1:0]        ab_le_n,
  input  logic [HALVES-1:0]        ab_oe_n,
  input  logic [HALVES-1:0]        ba_en_n,
  input  logic [HALVES-1:0]        ba_le_n,
  input  logic [HALVES-1:0]        ba_oe_n,
  input  logic [HALVES*HALF_W-1:0] a_in,
  output logic [HALVES*HALF_W-1:0] a_out,
  output logic [HALVES-1:0]        a_oe,
  input  logic [HALVES*HALF_W-1:0] b_in,
  output logic [HALVES*HALF_W-1:0] b_out,
  output logic [HALVES-1:0]        b_oe,
  output logic [HALVES-1:0]        contention
);

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic [HALF_W-1:0] ab_q;
    logic [HALF_W-1:0] ba_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        ab_q <= '0;
        ba_q <= '0;
      end else begin
        if (!ab_en_n[h] && !ab_le_n[h]) ab_q <= a_in[h*HALF_W +: HALF_W];
        if (!ba_en_n[h] && !ba_le_n[h]) ba_q <= b_in[h*HALF_W +: HALF_W];
      end
    end

    assign b_out[h*HALF_W +: HALF_W] = ab_q;
    assign a_out[h*HALF_W +: HALF_W] = ba_q;
    assign b_oe[h] = !rst && !ab_en_n[h] && !ab_oe_n[h];
    assign a_oe[h] = !rst && !ba_en_n[h] && !ba_oe_n[h];
    assign contention[h] = a_oe[h] && b_oe[h];
  end

endmodule

// File: rtl/dual_latch_xcvr_chk.sv
module dual_latch_xcvr_chk #(
  parameter int HALF_W = 8,
  parameter int HALVES = 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic [HALVES-1:0]        ab_en_n,
  input logic [HALVES-1:0]        ab_le_n,
  input logic [HALVES-1:0]        ab_oe_n,
  input logic [HALVES-1:0]        ba_en_n,
  input logic [HALVES-1:0]        ba_le_n,
  input logic [HALVES-1:0]        ba_oe_n,
  input logic [HALVES*HALF_W-1:0] a_in,
  input logic [HALVES*HALF_W-1:0] a_out,
  input logic [HALVES-1:0]        a_oe,
  input logic [HALVES*HALF_W-1:0] b_in,
  input logic [HALVES*HALF_W-1:0] b_out,
  input logic [HALVES-1:0]        b_oe,
  input logic [HALVES-1:0]        contention
);

  for (genvar h = 0; h < HALVES; h++) begin : g_chk
    AST_AB_LOAD: assert property (@(posedge clk) disable iff (rst)
      (!ab_en_n[h] && !ab_le_n[h]) |=> b_out[h*HALF_W +: HALF_W] == $past(a_in[h*HALF_W +: HALF_W])); // R2
    AST_AB_HOLD_EN: assert property (@(posedge clk) disable iff (rst)
      ab_en_n[h] |=> $stable(b_out[h*HALF_W +: HALF_W])); // R3
    AST_AB_HOLD_LE: assert property (@(posedge clk) disable iff (rst)
      ab_le_n[h] |=> $stable(b_out[h*HALF_W +: HALF_W])); // R4
    AST_B_DRIVE_GATED: assert property (@(posedge clk) disable iff (rst)
      b_oe[h] |-> (!ab_en_n[h] && !ab_oe_n[h])); // R5
    AST_BA_LOAD: assert property (@(posedge clk) disable iff (rst)
      (!ba_en_n[h] && !ba_le_n[h]) |=> a_out[h*HALF_W +: HALF_W] == $past(b_in[h*HALF_W +: HALF_W])); // R7
    AST_BA_HOLD: assert property (@(posedge clk) disable iff (rst)
      (ba_en_n[h] || ba_le_n[h]) |=> $stable(a_out[h*HALF_W +: HALF_W])); // R7
    AST_CONTENTION_BOTH: assert property (@(posedge clk) disable iff (rst)
      contention[h] |-> (a_oe[h] && b_oe[h])); // R10
  end

endmodule

bind dual_latch_xcvr dual_latch_xcvr_chk #(.HALF_W(HALF_W), .HALVES(HALVES)) chk_i (.*);

// File: tb/dual_latch_xcvr_tb_top.sv
`timescale 1ns/1ps
module dual_latch_xcvr_tb_top;
  localparam int W = 8;
  localparam int H = 2;
  localparam int BW = W * H;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [H-1:0] ab_en_n = '0, ab_le_n = '0, ab_oe_n = '0;
  logic [H-1:0] ba_en_n = '0, ba_le_n = '0, ba_oe_n = '0;
  logic [BW-1:0] a_in = '1, b_in = '1;
  logic [BW-1:0] a_out, b_out;
  logic [H-1:0] a_oe, b_oe, contention;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] m_ab [H];
  logic [W-1:0] m_ba [H];
  string tag_ab [H];
  string tag_ba [H];

  always #2 clk = ~clk;

  dual_latch_xcvr #(.HALF_W(W), .HALVES(H)) dut_i (
    .clk(clk), .rst(rst),
    .ab_en_n(ab_en_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
    .ba_en_n(ba_en_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .contention(contention)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_store(input string tb, input string tf);
    for (int h = 0; h < H; h++) begin
      chk({tag_ab[h], tb}, 32'(b_out[h*W +: W]), 32'(m_ab[h]));
      chk({tag_ba[h], tf}, 32'(a_out[h*W +: W]), 32'(m_ba[h]));
    end
  endtask

  task automatic chk_enables();
    for (int h = 0; h < H; h++) begin
      logic eb, ea;
      eb = !rst && !ab_en_n[h] && !ab_oe_n[h];
      ea = !rst && !ba_en_n[h] && !ba_oe_n[h];
      chk("R5 b_oe", 32'(b_oe[h]), 32'(eb));
      chk("R7 a_oe", 32'(a_oe[h]), 32'(ea));
      chk("R10 contention", 32'(contention[h]), 32'(eb && ea));
    end
  endtask

  task automatic model_edge();
    for (int h = 0; h < H; h++) begin
      if (rst) begin
        m_ab[h] = '0; m_ba[h] = '0; tag_ab[h] = "R1"; tag_ba[h] = "R1";
      end else begin
        if (!ab_en_n[h] && !ab_le_n[h]) begin m_ab[h] = a_in[h*W +: W]; tag_ab[h] = "R2"; end
        else if (ab_en_n[h]) tag_ab[h] = "R3";
        else tag_ab[h] = "R4";
        if (!ba_en_n[h] && !ba_le_n[h]) begin m_ba[h] = b_in[h*W +: W]; tag_ba[h] = "R7 load"; end
        else tag_ba[h] = "R7 hold";
      end
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int h = 0; h < H; h++) begin m_ab[h] = 'x; m_ba[h] = 'x; end
    // R1: reset with all controls low, outputs must stay disabled
    @(negedge clk);
    chk_enables();
    chk("R1 a_oe in reset", 32'(a_oe), 32'd0);
    @(posedge clk); model_edge();
    @(negedge clk);
    chk_store(" b_out after reset R1", " a_out after reset R1");
    chk("R1 contention in reset", 32'(contention), 32'd0);
    rst = 1'b0;
    ab_en_n = '1; ab_le_n = '1; ab_oe_n = '1;
    ba_en_n = '1; ba_le_n = '1; ba_oe_n = '1;

    // R8 R9: directed load of half 0 A-to-B only
    @(negedge clk);
    a_in = 16'h3CA5; b_in = 16'h7E81;
    ab_en_n = 2'b10; ab_le_n = 2'b10;
    @(posedge clk); model_edge();
    @(negedge clk);
    ab_en_n = '1; ab_le_n = '1; a_in = 16'h0000;
    chk("R2 half0 b_out", 32'(b_out[7:0]), 32'h00A5);
    chk("R8 half0 a_out untouched", 32'(a_out[7:0]), 32'h0);
    chk("R9 half1 b_out untouched", 32'(b_out[15:8]), 32'h0);
    chk("R9 half1 a_out untouched", 32'(a_out[15:8]), 32'h0);
    chk("R6 b_out shown while b_oe low", 32'(b_oe), 32'h0);
    @(posedge clk); model_edge();
    @(negedge clk);
    chk("R3 capture held", 32'(b_out[7:0]), 32'h00A5);

    // Exhaustive sweep over all twelve control bits
    for (int i = 0; i < 4096; i++) begin
      logic [11:0] c;
      logic [15:0] k;
      c = 12'(i) ^ 12'(i >> 1);
      k = 16'(i);
      chk_store(" b_out R6", " a_out R6");
      for (int h = 0; h < H; h++) begin
        {ab_en_n[h], ab_le_n[h], ab_oe_n[h], ba_en_n[h], ba_le_n[h], ba_oe_n[h]} = c[h*6 +: 6];
      end
      a_in = (k * 16'h9E37) ^ 16'h5A5A;
      b_in = ~(k * 16'h3C6B);
      #1;
      chk_enables();
      @(posedge clk); model_edge();
      @(negedge clk);
    end
    chk_store(" b_out R6", " a_out R6");

    // R1: mid-run reset clears everything
    ab_en_n = '0; ab_le_n = '0; ab_oe_n = '0;
    ba_en_n = '0; ba_le_n = '0; ba_oe_n = '0;
    rst = 1'b1;
    #1;
    chk("R1 b_oe forced off", 32'(b_oe), 32'h0);
    chk("R1 a_oe forced off", 32'(a_oe), 32'h0);
    chk("R1 contention forced off", 32'(contention), 32'h0);
    @(posedge clk); model_edge();
    @(negedge clk);
    chk("R1 b_out cleared", 32'(b_out), 32'h0);
    chk("R1 a_out cleared", 32'(a_out), 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule